// File: doc/BRIEF.md
# Multiplexed Signaling Bus Interleaver

This block takes the ABCD signaling nibbles of several E1 receive channels and sends them out bit-serially on one shared high-rate signaling line. The output is interleaved slot by slot across the framers, so the line carries framer 1 channel 0, framer 2 channel 0, and onward through every framer before it moves to channel 1. Each framer's place in that rotation comes from its own programmable slot offset.

Every bus slot is eight bits long and its first bit goes out first. The first four bits of a slot are filler at logic 1. The last four carry A, B, C and D. A frame pulse, whose active level is programmable, marks bit 1 of bus slot 0 and realigns the bit and slot counters. Between pulses the block runs freely. A rate bit selects a frame of 128 bus slots or a frame of 256 bus slots. At the higher rate the same interleave uses a stride of eight slots, and the slots that no framer claims carry filler. When a framer has lost signaling multiframe and its force enable is set, its nibble is replaced by all ones.

Top module: `sigmux_interleaver`

## Requirements
- R1: From reset until the first active frame pulse is sampled, `sig_out` is held at 1.
- R2: When the frame pulse is sampled active on a rising clock edge, `sig_out` carries bit 1 of bus slot 0 in the following cycle, and each later cycle carries the next bit. A pulse in the middle of a frame restarts the sequence at bit 1 of slot 0.
- R3: Each bus slot is 8 clocks long. Bits 1 to 4 are always 1. Bits 5, 6, 7 and 8 carry nibble bits 3 (A), 2 (B), 1 (C) and 0 (D).
- R4: With `hi_rate` = 0 the frame has 128 slots (1024 clocks). Framer f, channel k occupies bus slot (off_f + 4·k) mod 128, where off_f is `slot_off[f*7 +: 7]`. Its nibble is `sig_tab[(f*32+k)*4 +: 4]`.
- R5: With `hi_rate` = 1 the frame has 256 slots (2048 clocks), and framer f, channel k occupies bus slot (off_f + 8·k) mod 256.
- R6: A bus slot that no framer occupies is all ones.
- R7: When two or more framers map to the same bus slot, the framer with the lowest index supplies the nibble.
- R8: When both `oomf[f]` and `ais_en[f]` are 1, framer f's nibble is sent as 1111. `oomf[f]` alone has no effect.
- R9: With `fp_pol` = 1 the frame pulse is active high. With `fp_pol` = 0 it is active low.
- R10: With no pulse, the bit after the last bit of the frame is bit 1 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock, one bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_in | input | 1 | Frame pulse |
| fp_pol | input | 1 | Active level of the frame pulse |
| hi_rate | input | 1 | 0: 128-slot frame; 1: 256-slot frame |
| slot_off | input | NUM_FRM*OFF_W | Slot offset of each framer, framer f at bits f*OFF_W |
| sig_tab | input | NUM_FRM*E1_SLOTS*4 | ABCD nibble of each framer channel |
| oomf | input | NUM_FRM | Out-of-signaling-multiframe flag of each framer |
| ais_en | input | NUM_FRM | Enables the all-ones force for each framer |
| sig_out | output | 1 | Multiplexed serial signaling output |

## Verification
The bench builds the block with its default configuration: four framers of 32 channels and 7-bit offsets. This size is small enough to compare every bit of full 1024-clock and 2048-clock frames against an arithmetic model of the slot mapping. The sweeps cover round-robin, reversed, sparse high-rate and colliding offsets, a mix of forced and unforced framers, both pulse polarities, free-running wrap and a realigning pulse in mid-frame.

// File: rtl/sigmux_pkg.sv
package sigmux_pkg;
   localparam int NIB_W    = 4;
   localparam int SLOT_LEN = 8;
   localparam int BIT_W    = $clog2(SLOT_LEN);
   localparam int FILL_POS = 4;

   typedef enum logic {RATE_BASE = 1'b0, RATE_DOUBLE = 1'b1} rate_e;
endpackage

// File: rtl/sigmux_timebase.sv
module sigmux_timebase
   import sigmux_pkg::*;
#(
   parameter int LO_SLOTS = 128,
   parameter int SLOT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fp_in,
   input  logic              fp_pol,
   input  logic              hi_rate,
   output logic              run_nxt,
   output logic [SLOT_W-1:0] nxt_slot,
   output logic [BIT_W-1:0]  nxt_bit,
   output logic              run_q,
   output logic [SLOT_W-1:0] cur_slot,
   output logic [BIT_W-1:0]  cur_bit
);
   localparam logic [SLOT_W-1:0] LAST_LO = SLOT_W'(LO_SLOTS - 1);
   localparam logic [SLOT_W-1:0] LAST_HI = SLOT_W'(2 * LO_SLOTS - 1);
   localparam logic [BIT_W-1:0]  BIT_END = BIT_W'(SLOT_LEN - 1);

   logic              fp_act;
   logic [SLOT_W-1:0] last_slot;

   initial begin
      assert (2 * LO_SLOTS == (1 << SLOT_W))
         else $error("sigmux_timebase: SLOT_W does not fit LO_SLOTS");
   end

   assign fp_act    = (fp_in == fp_pol);
   assign last_slot = (rate_e'(hi_rate) == RATE_DOUBLE) ? LAST_HI : LAST_LO;
   assign run_nxt   = run_q | fp_act;

   always_comb begin
      if (fp_act) begin
         nxt_slot = '0;
         nxt_bit  = '0;
      end else if (cur_bit == BIT_END) begin
         nxt_bit  = '0;
         nxt_slot = (cur_slot >= last_slot) ? '0 : cur_slot + 1'b1;
      end else begin
         nxt_bit  = cur_bit + 1'b1;
         nxt_slot = cur_slot;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         cur_slot <= '0;
         cur_bit  <= '0;
      end else begin
         run_q    <= run_nxt;
         cur_slot <= run_nxt ? nxt_slot : '0;
         cur_bit  <= run_nxt ? nxt_bit : '0;
      end
   end

   // R2: a sampled pulse puts bit 1 of slot 0 on the line next
   p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fp_act |=> (cur_slot == '0 && cur_bit == '0));

   // R10: bit advance inside a slot without a pulse
   p_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !fp_act && cur_bit != BIT_END) |=>
         (cur_bit == $past(cur_bit) + 1'b1 && cur_slot == $past(cur_slot)));

   // R10: end of frame wraps to slot 0
   p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !fp_act && cur_bit == BIT_END && cur_slot == last_slot) |=>
         (cur_slot == '0 && cur_bit == '0));
endmodule

// File: rtl/sigmux_slot_map.sv
module sigmux_slot_map
   import sigmux_pkg::*;
#(
   parameter int NUM_FRM  = 4,
   parameter int OFF_W    = 7,
   parameter int SLOT_W   = 8,
   parameter int K_W      = 5,
   parameter int LO_SLOTS = 128,
   parameter int FRM_W    = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SLOT_W-1:0]        slot,
   input  logic                     hi_rate,
   input  logic [NUM_FRM*OFF_W-1:0] slot_off,
   output logic                     hit,
   output logic [FRM_W-1:0]         sel_frm,
   output logic [K_W-1:0]           sel_k
);
   localparam int STR_LO_W = $clog2(NUM_FRM);
   localparam int STR_HI_W = STR_LO_W + 1;
   localparam logic [SLOT_W-1:0] LO_MASK = SLOT_W'(LO_SLOTS - 1);

   logic [NUM_FRM-1:0] claim;
   logic [K_W-1:0]     k_arr [NUM_FRM];
   logic [NUM_FRM-1:0] low_mask;

   initial begin
      assert (OFF_W <= SLOT_W)
         else $error("sigmux_slot_map: offset wider than slot index");
      assert ((NUM_FRM & (NUM_FRM - 1)) == 0 && NUM_FRM >= 2)
         else $error("sigmux_slot_map: NUM_FRM must be a power of two");
   end

   for (genvar f = 0; f < NUM_FRM; f++) begin : g_frm
      logic [SLOT_W-1:0] d_raw;
      logic [SLOT_W-1:0] d_m;
      assign d_raw = slot - SLOT_W'(slot_off[f*OFF_W +: OFF_W]);
      assign d_m   = hi_rate ? d_raw : (d_raw & LO_MASK);
      assign claim[f] = hi_rate ? (d_m[STR_HI_W-1:0] == '0)
                                : (d_m[STR_LO_W-1:0] == '0);
      assign k_arr[f] = hi_rate ? K_W'(d_m >> STR_HI_W)
                                : K_W'(d_m >> STR_LO_W);
   end

   always_comb begin
      sel_frm = '0;
      for (int f = NUM_FRM - 1; f >= 0; f--) begin
         if (claim[f]) sel_frm = FRM_W'(f);
      end
   end

   assign hit      = |claim;
   assign sel_k    = k_arr[sel_frm];
   assign low_mask = NUM_FRM'((1 << sel_frm) - 1);

   // R7: the chosen framer claims the slot and no lower index does
   p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (claim[sel_frm] && (claim & low_mask) == '0));
endmodule

// File: rtl/sigmux_bit_sel.sv
module sigmux_bit_sel
   import sigmux_pkg::*;
#(
   parameter int NUM_FRM  = 4,
   parameter int E1_SLOTS = 32,
   parameter int K_W      = 5,
   parameter int FRM_W    = 2,
   parameter bit FILL_BIT = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              hit,
   input  logic [FRM_W-1:0]                  sel_frm,
   input  logic [K_W-1:0]                    sel_k,
   input  logic [BIT_W-1:0]                  bitn,
   input  logic [NUM_FRM*E1_SLOTS*NIB_W-1:0] sig_tab,
   input  logic [NUM_FRM-1:0]                oomf,
   input  logic [NUM_FRM-1:0]                ais_en,
   output logic                              bit_val
);
   logic [NUM_FRM-1:0] frc;
   logic [NIB_W-1:0]   nib_raw;
   logic [NIB_W-1:0]   nib_eff;
   logic               in_fill;

   for (genvar f = 0; f < NUM_FRM; f++) begin : g_force
      assign frc[f] = oomf[f] & ais_en[f];
   end

   always_comb begin
      int idx;
      idx     = (int'(sel_frm) * E1_SLOTS + int'(sel_k)) * NIB_W;
      nib_raw = sig_tab[idx +: NIB_W];
   end

   assign nib_eff = frc[sel_frm] ? {NIB_W{1'b1}} : nib_raw;
   assign in_fill = !hit || (bitn < BIT_W'(FILL_POS));
   assign bit_val = in_fill ? FILL_BIT : nib_eff[~bitn[1:0]];

   // R8: a forced framer's signaling bits are all ones
   p_force_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !in_fill && oomf[sel_frm] && ais_en[sel_frm]) |-> bit_val);
endmodule

// File: rtl/sigmux_interleaver.sv
module sigmux_interleaver
   import sigmux_pkg::*;
#(
   parameter int NUM_FRM  = 4,
   parameter int E1_SLOTS = 32,
   parameter int OFF_W    = 7,
   parameter bit FILL_BIT = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              fp_in,
   input  logic                              fp_pol,
   input  logic                              hi_rate,
   input  logic [NUM_FRM*OFF_W-1:0]          slot_off,
   input  logic [NUM_FRM*E1_SLOTS*NIB_W-1:0] sig_tab,
   input  logic [NUM_FRM-1:0]                oomf,
   input  logic [NUM_FRM-1:0]                ais_en,
   output logic                              sig_out
);
   localparam int LO_SLOTS = NUM_FRM * E1_SLOTS;
   localparam int SLOT_W   = $clog2(LO_SLOTS) + 1;
   localparam int K_W      = $clog2(E1_SLOTS);
   localparam int FRM_W    = $clog2(NUM_FRM);

   logic              run_nxt, run_q;
   logic [SLOT_W-1:0] nxt_slot, cur_slot;
   logic [BIT_W-1:0]  nxt_bit, cur_bit;
   logic              hit;
   logic [FRM_W-1:0]  sel_frm;
   logic [K_W-1:0]    sel_k;
   logic              bit_val;

   initial begin
      assert ((E1_SLOTS & (E1_SLOTS - 1)) == 0 && E1_SLOTS >= 2)
         else $error("sigmux_interleaver: E1_SLOTS must be a power of two");
   end

   sigmux_timebase #(
      .LO_SLOTS (LO_SLOTS),
      .SLOT_W   (SLOT_W)
   ) u_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .fp_in    (fp_in),
      .fp_pol   (fp_pol),
      .hi_rate  (hi_rate),
      .run_nxt  (run_nxt),
      .nxt_slot (nxt_slot),
      .nxt_bit  (nxt_bit),
      .run_q    (run_q),
      .cur_slot (cur_slot),
      .cur_bit  (cur_bit)
   );

   sigmux_slot_map #(
      .NUM_FRM  (NUM_FRM),
      .OFF_W    (OFF_W),
      .SLOT_W   (SLOT_W),
      .K_W      (K_W),
      .LO_SLOTS (LO_SLOTS),
      .FRM_W    (FRM_W)
   ) u_slot_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot     (nxt_slot),
      .hi_rate  (hi_rate),
      .slot_off (slot_off),
      .hit      (hit),
      .sel_frm  (sel_frm),
      .sel_k    (sel_k)
   );

   sigmux_bit_sel #(
      .NUM_FRM  (NUM_FRM),
      .E1_SLOTS (E1_SLOTS),
      .K_W      (K_W),
      .FRM_W    (FRM_W),
      .FILL_BIT (FILL_BIT)
   ) u_bit_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .sel_frm  (sel_frm),
      .sel_k    (sel_k),
      .bitn     (nxt_bit),
      .sig_tab  (sig_tab),
      .oomf     (oomf),
      .ais_en   (ais_en),
      .bit_val  (bit_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_out <= FILL_BIT;
      else        sig_out <= run_nxt ? bit_val : FILL_BIT;
   end

   // R1: idle at filler until the first pulse
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (sig_out == FILL_BIT));

   // R3: the first four bits of every slot on the line are filler
   p_fill_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cur_bit < BIT_W'(FILL_POS)) |-> (sig_out == FILL_BIT));

   // R1: once started, the line stays in running state
   p_stay_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> run_q);

   // R6: slot index stays inside the selected frame length
   p_slot_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_rate && $stable(hi_rate) && run_q && $past(!hi_rate))
         |-> (cur_slot < SLOT_W'(LO_SLOTS)));
endmodule

// File: tb/test_sigmux_interleaver.sv
module test_sigmux_interleaver;
   localparam int NF  = 4;
   localparam int NS  = 32;
   localparam int OW  = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fp_in = 1'b0;
   logic fp_pol = 1'b1;
   logic hi_rate = 1'b0;
   logic [NF*OW-1:0]  slot_off = '0;
   logic [NF*NS*4-1:0] sig_tab = '0;
   logic [NF-1:0] oomf = '0;
   logic [NF-1:0] ais_en = '0;
   logic sig_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sigmux_interleaver i_sigmux_interleaver (
      .clk      (clk),
      .rst_n    (rst_n),
      .fp_in    (fp_in),
      .fp_pol   (fp_pol),
      .hi_rate  (hi_rate),
      .slot_off (slot_off),
      .sig_tab  (sig_tab),
      .oomf     (oomf),
      .ais_en   (ais_en),
      .sig_out  (sig_out)
   );

   task automatic chk(input logic got, input logic exp, input string rq, input int pos);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s pos %0d: got %b expected %b", rq, pos, got, exp);
      end
   endtask

   function automatic logic exp_bit(input int slot, input int bitn);
      int n, st;
      if (bitn < 4) return 1'b1;
      n  = hi_rate ? 256 : 128;
      st = hi_rate ? 8 : 4;
      for (int f = 0; f < NF; f++) begin
         int d, k;
         logic [3:0] nib;
         d = ((slot - int'(slot_off[f*OW +: OW])) % n + n) % n;
         if (d % st == 0) begin
            k   = d / st;
            nib = (oomf[f] && ais_en[f]) ? 4'hF : sig_tab[(f*NS + k)*4 +: 4];
            return nib[3 - (bitn - 4)];
         end
      end
      return 1'b1;
   endfunction

   task automatic load_tab(input int seed);
      for (int f = 0; f < NF; f++)
         for (int k = 0; k < NS; k++)
            sig_tab[(f*NS + k)*4 +: 4] = 4'((seed + f*7 + k*3 + (k >> 2)) & 15);
   endtask

   task automatic set_off(input int o0, input int o1, input int o2, input int o3);
      slot_off = {7'(o3), 7'(o2), 7'(o1), 7'(o0)};
   endtask

   // pulse the frame marker, then check nchk consecutive line bits
   task automatic frame(input int nchk, input string rq);
      int n;
      n = hi_rate ? 256 : 128;
      @(negedge clk); fp_in = fp_pol;
      @(negedge clk); fp_in = ~fp_pol;
      for (int p = 0; p < nchk; p++) begin
         if (p > 0) @(negedge clk);
         chk(sig_out, exp_bit((p / 8) % n, p % 8), rq, p);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      fp_in = ~fp_pol;
      // R1: reset state and idle before any pulse
      repeat (3) @(negedge clk);
      chk(sig_out, 1'b1, "R1", -1);
      rst_n = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk(sig_out, 1'b1, "R1", i);
      end

      // R4 / R3: base rate, round-robin offsets, then R10 wrap
      load_tab(1); set_off(0, 1, 2, 3);
      frame(1024 + 40, "R4");

      // R4: reversed offsets, other nibbles
      load_tab(9); set_off(3, 2, 1, 0);
      frame(1024, "R4");

      // R5 / R6: double rate, half the positions unused
      hi_rate = 1'b1; load_tab(4); set_off(0, 1, 2, 3);
      frame(2048, "R5");

      // R5: double rate, sparse offsets
      set_off(5, 0, 2, 7);
      frame(2048 + 24, "R5");

      // R7 / R6: colliding offsets at base rate
      hi_rate = 1'b0; load_tab(6); set_off(0, 0, 1, 2);
      frame(1024, "R7");

      // R8: framer 1 forced; framer 2 has only the flag
      oomf = 4'b0110; ais_en = 4'b0011; set_off(0, 1, 2, 3);
      frame(1024, "R8");
      oomf = '0; ais_en = '0;

      // R9: active-low pulse
      fp_pol = 1'b0; fp_in = 1'b1; load_tab(12);
      frame(1024, "R9");

      // R2: realign in mid-frame
      frame(300, "R2");
      frame(1024, "R2");

      // R10: free run through a full frame without a pulse
      for (int p = 1024; p < 2048 + 16; p++) begin
         @(negedge clk);
         chk(sig_out, exp_bit(((p) / 8) % 128, p % 8), "R10", p);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule